// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache

This block is a data cache that sits between a processor load/store port, which moves one word per request, and a memory port, which moves a whole line per request. The cache has a fixed four ways per set. Both the number of sets and the line size are parameters. An incoming address is cut into a tag, a set index and a byte offset. The indexed set is searched in all four ways at once. A hit is served from on-chip storage in a single cycle.

Stores follow a write-back, write-allocate policy. A store that hits only changes the cached copy and marks that line dirty. A miss claims a line in the set. The replacement order is:
- A free way is taken first.
- If no way is free, a three-bit tree pseudo-LRU picks the victim.
- If the victim is dirty, its whole line is sent to memory before the refill is requested.
- A store miss merges its bytes into the refilled line, and that line is then dirty.

Only one miss is handled at a time. The processor port is held off until that miss has been answered.

Top module: `dcache_wb`

## Requirements
- R1: After reset, every line is invalid and clean and the tree bits are zero. `cpu_req_ready` is 1, and `cpu_resp_valid` and `mem_req_valid` are 0. The first access to any line is a miss and writes nothing back.
- R2: The address fields are laid out as follows:
  - bits [OFF_W-1:0] are the byte offset, where OFF_W = log2(BLOCK_BYTES);
  - the next log2(SETS) bits are the set index;
  - the remaining upper bits are the tag.
  
  Memory requests carry the line-aligned address (the offset bits are zero). Byte k of a line is bits [8k+7:8k] of the line data. A word at byte offset o occupies bytes o to o+3.
- R3: A valid line with a matching tag hits in whichever way it sits. At most one way of a set ever matches. A read hit returns the current word, where byte b of the word comes from byte address (addr+b).
- R4: An access is accepted on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both 1. A hit raises `cpu_resp_valid` in the next cycle, and the port stays ready. A hit causes no memory request.
- R5: A store hit writes only the bytes whose `cpu_req_be` bit b is 1; bit b selects `cpu_req_wdata[8b+7:8b]`. The line becomes dirty, and no memory write is issued.
- R6: On a miss, `cpu_req_ready` goes low from the cycle after acceptance until the response. The response cycle itself also has ready low, and ready returns to 1 in the cycle after it.
- R7: When the victim is valid and dirty, the whole line is written to memory at the victim's own line address. This write completes before the refill read is requested. No memory write happens for any other reason.
- R8: When the victim is clean or invalid, it is replaced with no memory write.
- R9: A store miss first refills the line from memory. It then merges the enabled bytes into the line and leaves the line dirty.
- R10: If the indexed set has an invalid way, the lowest-numbered invalid way is filled.
- R11: When every way is valid, the victim is taken from the set's tree bits t[2:0]:
  - if t0 is 0, the victim is way t1; if t0 is 1, the victim is way 2+t2;
  - a hit or fill of way w sets t0 to (w<2);
  - for w<2 it sets t1 to (w==0);
  - for w≥2 it sets t2 to (w==2).
- R12: Once `mem_req_valid` is raised, it stays high, and `mem_req_addr` and `mem_req_write` stay unchanged, until a cycle in which `mem_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address (word aligned) |
| cpu_req_wdata | input | WORD_W | Store data |
| cpu_req_be | input | WORD_W/8 | Store byte enables |
| cpu_resp_valid | output | 1 | Response strobe, one cycle |
| cpu_resp_rdata | output | WORD_W | Load data (merged word for stores) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | ADDR_W | Line-aligned address |
| mem_req_wdata | output | 8*BLOCK_BYTES | Line being written back |
| mem_resp_valid | input | 1 | Refill data present, one cycle |
| mem_resp_rdata | input | 8*BLOCK_BYTES | Refill line |

## Verification
The bench keeps its own model of tags, valid and dirty bits and tree bits. From that model it predicts, for every access, whether it hits, which way is the victim, and whether a write-back must occur.

The directed cases target three situations:
- Filling a set from empty. A design that ignored free ways would evict a just-filled line and miss on the next access.
- Evicting a set that is fully dirty. A design that wrote back the wrong way or the wrong address would send memory a stale line, and later reads would return old data.
- A store miss. A design that skipped the merge would lose the stored bytes after the line is evicted and refilled.

Random traffic over eight conflicting tags and random byte enables exposes the remaining faults. A wrong tree update moves write-backs to unexpected addresses. Mishandled byte enables corrupt neighbouring bytes. A slow or early hit response breaks the one-cycle latency check.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

   localparam int unsigned DC_WAYS   = 4;
   localparam int unsigned DC_WAY_W  = 2;
   localparam int unsigned DC_TREE_W = DC_WAYS - 1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WB_REQ,
      ST_RF_REQ,
      ST_RF_WAIT,
      ST_RESPOND
   } dc_state_e;

   typedef logic [DC_WAY_W-1:0] dc_way_t;

endpackage

// File: rtl/dcache_plru.sv
module dcache_plru
   import dcache_pkg::*;
#(
   parameter int unsigned SETS  = 8,
   parameter int unsigned IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output dc_way_t          victim_way,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  dc_way_t          touch_way
);

   logic [DC_TREE_W-1:0] tree_q [SETS];
   logic [DC_TREE_W-1:0] rd_tree;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (touch_en) begin
         tree_q[touch_idx][0] <= ~touch_way[1];
         if (!touch_way[1]) tree_q[touch_idx][1] <= ~touch_way[0];
         else               tree_q[touch_idx][2] <= ~touch_way[0];
      end
   end

   assign rd_tree    = tree_q[rd_idx];
   assign victim_way = rd_tree[0] ? {1'b1, rd_tree[2]} : {1'b0, rd_tree[1]};

endmodule

// File: rtl/dcache_tag_match.sv
module dcache_tag_match
   import dcache_pkg::*;
#(
   parameter int unsigned TAG_W = 25
) (
   input  logic [DC_WAYS-1:0]             valid_vec,
   input  logic [DC_WAYS-1:0][TAG_W-1:0]  tag_vec,
   input  logic [TAG_W-1:0]               tag_in,
   output logic [DC_WAYS-1:0]             hit_vec,
   output logic                           hit,
   output dc_way_t                        hit_way
);

   for (genvar w = 0; w < DC_WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valid_vec[w] && (tag_vec[w] == tag_in);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < DC_WAYS; w++) begin
         if (hit_vec[w]) hit_way = dc_way_t'(w);
      end
   end

endmodule

// File: rtl/dcache_victim_pick.sv
module dcache_victim_pick
   import dcache_pkg::*;
(
   input  logic [DC_WAYS-1:0] valid_vec,
   input  dc_way_t            plru_way,
   output dc_way_t            fill_way
);

   logic    have_free;
   dc_way_t free_way;

   always_comb begin
      have_free = 1'b0;
      free_way  = '0;
      for (int w = DC_WAYS - 1; w >= 0; w--) begin
         if (!valid_vec[w]) begin
            have_free = 1'b1;
            free_way  = dc_way_t'(w);
         end
      end
   end

   assign fill_way = have_free ? free_way : plru_way;

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
   import dcache_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned SETS        = 8,
   parameter int unsigned BLOCK_BYTES = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_req_valid,
   output logic                      cpu_req_ready,
   input  logic                      cpu_req_write,
   input  logic [ADDR_W-1:0]         cpu_req_addr,
   input  logic [WORD_W-1:0]         cpu_req_wdata,
   input  logic [WORD_W/8-1:0]       cpu_req_be,
   output logic                      cpu_resp_valid,
   output logic [WORD_W-1:0]         cpu_resp_rdata,
   output logic                      mem_req_valid,
   input  logic                      mem_req_ready,
   output logic                      mem_req_write,
   output logic [ADDR_W-1:0]         mem_req_addr,
   output logic [8*BLOCK_BYTES-1:0]  mem_req_wdata,
   input  logic                      mem_resp_valid,
   input  logic [8*BLOCK_BYTES-1:0]  mem_resp_rdata
);

   localparam int unsigned WORD_BYTES = WORD_W / 8;
   localparam int unsigned LINE_W     = 8 * BLOCK_BYTES;
   localparam int unsigned OFF_W      = $clog2(BLOCK_BYTES);
   localparam int unsigned BOFF_W     = $clog2(WORD_BYTES);
   localparam int unsigned WSEL_W     = OFF_W - BOFF_W;
   localparam int unsigned IDX_W      = $clog2(SETS);
   localparam int unsigned TAG_W      = ADDR_W - IDX_W - OFF_W;

   if ((SETS < 2) || ((1 << IDX_W) != SETS)) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if ((WORD_W % 8) != 0 || (1 << BOFF_W) != WORD_BYTES) begin : g_bad_word
      $error("WORD_W must be a power-of-two number of bytes");
   end
   if ((1 << OFF_W) != BLOCK_BYTES || BLOCK_BYTES < 2 * WORD_BYTES) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two holding at least two words");
   end
   if (ADDR_W <= IDX_W + OFF_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   // storage
   logic [DC_WAYS-1:0][TAG_W-1:0]  tag_mem  [SETS];
   logic [DC_WAYS-1:0][LINE_W-1:0] data_mem [SETS];
   logic [DC_WAYS-1:0]             valid_q  [SETS];
   logic [DC_WAYS-1:0]             dirty_q  [SETS];

   // control state
   dc_state_e           state_q;
   logic                req_write_q;
   logic [ADDR_W-1:0]   req_addr_q;
   logic [WORD_W-1:0]   req_wdata_q;
   logic [WORD_BYTES-1:0] req_be_q;
   dc_way_t             vic_way_q;
   logic                vic_dirty_q;
   logic                resp_valid_q;
   logic [WORD_W-1:0]   resp_data_q;

   // address fields
   logic [IDX_W-1:0]  lk_idx, rq_idx;
   logic [TAG_W-1:0]  lk_tag, rq_tag;
   logic [WSEL_W-1:0] lk_wsel, rq_wsel;

   assign lk_idx  = cpu_req_addr[OFF_W +: IDX_W];
   assign lk_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
   assign lk_wsel = cpu_req_addr[BOFF_W +: WSEL_W];
   assign rq_idx  = req_addr_q[OFF_W +: IDX_W];
   assign rq_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
   assign rq_wsel = req_addr_q[BOFF_W +: WSEL_W];

   function automatic logic [LINE_W-1:0] merge_word(
      input logic [LINE_W-1:0]     line,
      input logic [WSEL_W-1:0]     wsel,
      input logic [WORD_W-1:0]     wdata,
      input logic [WORD_BYTES-1:0] be
   );
      logic [LINE_W-1:0] res;
      res = line;
      for (int b = 0; b < WORD_BYTES; b++) begin
         if (be[b]) res[int'(wsel) * WORD_W + b * 8 +: 8] = wdata[b * 8 +: 8];
      end
      return res;
   endfunction

   // lookup
   logic [DC_WAYS-1:0] hit_vec;
   logic               lookup_hit;
   dc_way_t            hit_way;
   dc_way_t            plru_way;
   dc_way_t            fill_way;

   dcache_tag_match #(.TAG_W(TAG_W)) u_match (
      .valid_vec (valid_q[lk_idx]),
      .tag_vec   (tag_mem[lk_idx]),
      .tag_in    (lk_tag),
      .hit_vec   (hit_vec),
      .hit       (lookup_hit),
      .hit_way   (hit_way)
   );

   logic    accept;
   logic    hit_acc;
   logic    miss_acc;
   logic    fill_now;
   logic    touch_en;
   logic [IDX_W-1:0] touch_idx;
   dc_way_t touch_way;

   assign cpu_req_ready = (state_q == ST_IDLE);
   assign accept        = cpu_req_valid && cpu_req_ready;
   assign hit_acc       = accept && lookup_hit;
   assign miss_acc      = accept && !lookup_hit;
   assign fill_now      = (state_q == ST_RF_WAIT) && mem_resp_valid;

   assign touch_en  = hit_acc || fill_now;
   assign touch_idx = fill_now ? rq_idx : lk_idx;
   assign touch_way = fill_now ? vic_way_q : hit_way;

   dcache_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (lk_idx),
      .victim_way (plru_way),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .touch_way  (touch_way)
   );

   dcache_victim_pick u_pick (
      .valid_vec (valid_q[lk_idx]),
      .plru_way  (plru_way),
      .fill_way  (fill_way)
   );

   // line datapath
   logic [LINE_W-1:0] hit_line, hit_merged, fill_line;
   logic [LINE_W-1:0] wr_line;
   logic              data_we;
   logic [IDX_W-1:0]  wr_idx;
   dc_way_t           wr_way;

   assign hit_line   = data_mem[lk_idx][hit_way];
   assign hit_merged = merge_word(hit_line, lk_wsel, cpu_req_wdata, cpu_req_be);
   assign fill_line  = req_write_q ? merge_word(mem_resp_rdata, rq_wsel, req_wdata_q, req_be_q)
                                   : mem_resp_rdata;

   always_comb begin
      data_we = 1'b0;
      wr_idx  = lk_idx;
      wr_way  = hit_way;
      wr_line = hit_merged;
      if (hit_acc && cpu_req_write) begin
         data_we = 1'b1;
      end else if (fill_now) begin
         data_we = 1'b1;
         wr_idx  = rq_idx;
         wr_way  = vic_way_q;
         wr_line = fill_line;
      end
   end

   always_ff @(posedge clk) begin
      if (data_we) data_mem[wr_idx][wr_way] <= wr_line;
      if (fill_now) tag_mem[rq_idx][vic_way_q] <= rq_tag;
   end

   // control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         req_write_q  <= 1'b0;
         req_addr_q   <= '0;
         req_wdata_q  <= '0;
         req_be_q     <= '0;
         vic_way_q    <= '0;
         vic_dirty_q  <= 1'b0;
         resp_valid_q <= 1'b0;
         resp_data_q  <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
      end else begin
         resp_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (hit_acc) begin
                  resp_valid_q <= 1'b1;
                  resp_data_q  <= cpu_req_write ? hit_merged[int'(lk_wsel) * WORD_W +: WORD_W]
                                                : hit_line[int'(lk_wsel) * WORD_W +: WORD_W];
                  if (cpu_req_write) dirty_q[lk_idx][hit_way] <= 1'b1;
               end else if (miss_acc) begin
                  req_write_q <= cpu_req_write;
                  req_addr_q  <= cpu_req_addr;
                  req_wdata_q <= cpu_req_wdata;
                  req_be_q    <= cpu_req_be;
                  vic_way_q   <= fill_way;
                  vic_dirty_q <= valid_q[lk_idx][fill_way] && dirty_q[lk_idx][fill_way];
                  state_q     <= (valid_q[lk_idx][fill_way] && dirty_q[lk_idx][fill_way])
                                 ? ST_WB_REQ : ST_RF_REQ;
               end
            end
            ST_WB_REQ: begin
               if (mem_req_ready) begin
                  state_q <= ST_RF_REQ;
                  dirty_q[rq_idx][vic_way_q] <= 1'b0;
               end
            end
            ST_RF_REQ: begin
               if (mem_req_ready) state_q <= ST_RF_WAIT;
            end
            ST_RF_WAIT: begin
               if (mem_resp_valid) begin
                  valid_q[rq_idx][vic_way_q] <= 1'b1;
                  dirty_q[rq_idx][vic_way_q] <= req_write_q;
                  resp_valid_q <= 1'b1;
                  resp_data_q  <= fill_line[int'(rq_wsel) * WORD_W +: WORD_W];
                  state_q      <= ST_RESPOND;
               end
            end
            ST_RESPOND: state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_resp_valid = resp_valid_q;
   assign cpu_resp_rdata = resp_data_q;

   // memory port
   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = {rq_tag, rq_idx, {OFF_W{1'b0}}};
      mem_req_wdata = data_mem[rq_idx][vic_way_q];
      if (state_q == ST_WB_REQ) begin
         mem_req_valid = 1'b1;
         mem_req_write = 1'b1;
         mem_req_addr  = {tag_mem[rq_idx][vic_way_q], rq_idx, {OFF_W{1'b0}}};
      end else if (state_q == ST_RF_REQ) begin
         mem_req_valid = 1'b1;
      end
   end

endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk
   import dcache_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_req_valid,
   input logic               cpu_req_ready,
   input logic               cpu_resp_valid,
   input logic               mem_req_valid,
   input logic               mem_req_ready,
   input logic               mem_req_write,
   input logic [ADDR_W-1:0]  mem_req_addr,
   input logic               lookup_hit,
   input logic [DC_WAYS-1:0] hit_vec,
   input logic               vic_dirty_q
);

   // R3: tags in a set are unique among valid ways
   p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R4: hit answered in the next cycle
   p_hit_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_valid && cpu_req_ready && lookup_hit |=> cpu_resp_valid);

   // R6: a miss stalls the processor port
   p_miss_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_valid && cpu_req_ready && !lookup_hit |=> !cpu_req_ready);

   // R6: response of a miss is followed by a ready port
   p_resp_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp_valid && !cpu_req_ready |=> cpu_req_ready);

   // R7: memory writes only for dirty victims
   p_wb_dirty_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> vic_dirty_q);

   // R12: memory request held until taken
   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

endmodule

bind dcache_wb dcache_wb_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_req_valid  (cpu_req_valid),
   .cpu_req_ready  (cpu_req_ready),
   .cpu_resp_valid (cpu_resp_valid),
   .mem_req_valid  (mem_req_valid),
   .mem_req_ready  (mem_req_ready),
   .mem_req_write  (mem_req_write),
   .mem_req_addr   (mem_req_addr),
   .lookup_hit     (lookup_hit),
   .hit_vec        (hit_vec),
   .vic_dirty_q    (vic_dirty_q)
);

// File: tb/dcache_wb_test.sv
module dcache_wb_test;

   localparam int AW = 32;
   localparam int WW = 32;
   localparam int NS = 8;
   localparam int BB = 16;
   localparam int LW = 8 * BB;
   localparam int TW = AW - 3 - 4;
   localparam int NBLK = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          cpu_req_valid = 1'b0;
   logic          cpu_req_ready;
   logic          cpu_req_write = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [WW-1:0] cpu_req_wdata = '0;
   logic [3:0]    cpu_req_be = '0;
   logic          cpu_resp_valid;
   logic [WW-1:0] cpu_resp_rdata;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic          mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [LW-1:0] mem_req_wdata;
   logic          mem_resp_valid = 1'b0;
   logic [LW-1:0] mem_resp_rdata = '0;

   dcache_wb #(.ADDR_W(AW), .WORD_W(WW), .SETS(NS), .BLOCK_BYTES(BB)) uut (.*);

   int n_checks = 0;
   int n_bad = 0;
   int wb_cnt = 0;
   int rf_cnt = 0;
   logic [AW-1:0] last_wb_addr = '0;
   logic [AW-1:0] last_rf_addr = '0;

   logic [LW-1:0] mem_blk [NBLK];
   logic [7:0]    gold [NBLK*BB];

   logic [3:0]    m_valid [NS];
   logic [3:0]    m_dirty [NS];
   logic [TW-1:0] m_tag   [NS][4];
   logic [2:0]    m_tree  [NS];

   task automatic check(input bit ok, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] gold_word(input logic [AW-1:0] a);
      logic [WW-1:0] w;
      for (int b = 0; b < 4; b++) w[b*8 +: 8] = gold[int'(a[9:0]) + b];
      return w;
   endfunction

   function automatic logic [2:0] tree_touch(input logic [2:0] t, input int w);
      logic [2:0] r;
      r = t;
      r[0] = (w < 2);
      if (w < 2) r[1] = (w == 0);
      else       r[2] = (w == 2);
      return r;
   endfunction

   // memory responder
   initial begin : responder
      bit prev_valid = 0, prev_rdy = 0, prev_wr = 0, rd_pending = 0;
      logic [AW-1:0] prev_addr = '0;
      logic [LW-1:0] prev_wdata = '0;
      int delay = 0;
      int rd_blk = 0;
      forever begin
         @(negedge clk);
         mem_resp_valid = 1'b0;
         if (prev_valid && prev_rdy) begin
            if (prev_wr) begin
               mem_blk[int'(prev_addr[9:4])] = prev_wdata;
               wb_cnt++;
               last_wb_addr = prev_addr;
            end else begin
               rf_cnt++;
               last_rf_addr = prev_addr;
               rd_blk = int'(prev_addr[9:4]);
               delay = $urandom_range(1, 3);
               rd_pending = 1;
            end
         end else if (prev_valid && rst_n) begin
            check(mem_req_valid && mem_req_addr == prev_addr && mem_req_write == prev_wr,
                  "R12 request held until ready", LW'(mem_req_addr), LW'(prev_addr));
         end
         if (rd_pending) begin
            delay--;
            if (delay == 0) begin
               mem_resp_valid = 1'b1;
               mem_resp_rdata = mem_blk[rd_blk];
               rd_pending = 0;
            end
         end
         prev_valid = mem_req_valid;
         prev_wr    = mem_req_write;
         prev_addr  = mem_req_addr;
         prev_wdata = mem_req_wdata;
         mem_req_ready = mem_req_valid && ($urandom_range(0, 1) == 1);
         prev_rdy = mem_req_ready;
      end
   end

   task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [WW-1:0] wd, input logic [3:0] be);
      int idx, hitw, vic, wb0, rf0, cyc;
      bit exp_wb, saw_ready;
      logic [TW-1:0] tg;
      logic [AW-1:0] exp_wb_addr;
      logic [WW-1:0] exp_rd;
      idx = int'(addr[6:4]);
      tg  = addr[AW-1:7];
      hitw = -1;
      for (int w = 0; w < 4; w++) if (m_valid[idx][w] && m_tag[idx][w] == tg) hitw = w;
      vic = -1;
      for (int w = 3; w >= 0; w--) if (!m_valid[idx][w]) vic = w;
      if (vic < 0) vic = m_tree[idx][0] ? 2 + int'(m_tree[idx][2]) : int'(m_tree[idx][1]);
      exp_wb = (hitw < 0) && m_valid[idx][vic] && m_dirty[idx][vic];
      exp_wb_addr = {m_tag[idx][vic], 3'(idx), 4'b0};
      exp_rd = gold_word(addr);
      wb0 = wb_cnt;
      rf0 = rf_cnt;

      @(negedge clk);
      cpu_req_valid = 1'b1;
      cpu_req_write = wr;
      cpu_req_addr  = addr;
      cpu_req_wdata = wd;
      cpu_req_be    = be;
      check(cpu_req_ready, "R4 ready before access", LW'(cpu_req_ready), 1);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      if (hitw >= 0) begin
         check(cpu_resp_valid && cpu_req_ready, "R4 hit answered next cycle", LW'(cpu_resp_valid), 1);
      end else begin
         cyc = 0;
         saw_ready = 0;
         while (!cpu_resp_valid && cyc < 200) begin
            if (cpu_req_ready) saw_ready = 1;
            @(negedge clk);
            cyc++;
         end
         check(!saw_ready && cpu_resp_valid && !cpu_req_ready, "R6 port stalled through miss",
               LW'(saw_ready), 0);
      end
      if (!wr) check(cpu_resp_rdata == exp_rd, "R3 R9 read data", LW'(cpu_resp_rdata), LW'(exp_rd));
      else begin
         for (int b = 0; b < 4; b++) if (be[b]) gold[int'(addr[9:0]) + b] = wd[b*8 +: 8];
      end
      check(rf_cnt - rf0 == ((hitw < 0) ? 1 : 0), "R10 R11 hit or miss as predicted",
            LW'(rf_cnt - rf0), LW'((hitw < 0) ? 1 : 0));
      check(wb_cnt - wb0 == (exp_wb ? 1 : 0),
            (hitw >= 0 && wr) ? "R5 no write on store hit" : (exp_wb ? "R7 dirty victim written" : "R8 clean victim dropped"),
            LW'(wb_cnt - wb0), LW'(exp_wb ? 1 : 0));
      if (exp_wb) check(last_wb_addr == exp_wb_addr, "R7 R11 write-back address", LW'(last_wb_addr), LW'(exp_wb_addr));
      if (hitw < 0) check(last_rf_addr == {addr[AW-1:4], 4'b0}, "R2 refill address", LW'(last_rf_addr), LW'({addr[AW-1:4], 4'b0}));

      if (hitw >= 0) begin
         if (wr) m_dirty[idx][hitw] = 1'b1;
         m_tree[idx] = tree_touch(m_tree[idx], hitw);
      end else begin
         m_valid[idx][vic] = 1'b1;
         m_dirty[idx][vic] = wr;
         m_tag[idx][vic]   = tg;
         m_tree[idx] = tree_touch(m_tree[idx], vic);
      end
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] mk(input int tag, input int idx, input int word);
      return AW'(tag * NS * BB + idx * BB + word * 4);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1234_5678));
      for (int b = 0; b < NBLK * BB; b++) gold[b] = 8'(b * 7 + 3);
      for (int k = 0; k < NBLK; k++)
         for (int b = 0; b < BB; b++) mem_blk[k][b*8 +: 8] = gold[k * BB + b];
      for (int s = 0; s < NS; s++) begin
         m_valid[s] = '0;
         m_dirty[s] = '0;
         m_tree[s]  = '0;
         for (int w = 0; w < 4; w++) m_tag[s][w] = '0;
      end
      repeat (3) @(negedge clk);
      check(cpu_req_ready && !cpu_resp_valid && !mem_req_valid, "R1 outputs held in reset",
            LW'({cpu_req_ready, cpu_resp_valid, mem_req_valid}), LW'(3'b100));
      rst_n = 1'b1;
      @(negedge clk);
      check(cpu_req_ready && !cpu_resp_valid && !mem_req_valid, "R1 idle after reset",
            LW'({cpu_req_ready, cpu_resp_valid, mem_req_valid}), LW'(3'b100));

      // R1 R10: empty set fills every way without write-back
      for (int t = 0; t < 4; t++) access(0, mk(t, 0, t), '0, '0);
      for (int t = 0; t < 4; t++) access(0, mk(t, 0, 3 - t), '0, '0);
      // R5: store hits with partial enables
      access(1, mk(1, 0, 2), 32'hA1B2_C3D4, 4'b0101);
      access(0, mk(1, 0, 2), '0, '0);
      // R11: fifth tag evicts by tree
      access(0, mk(4, 0, 0), '0, '0);
      access(0, mk(5, 0, 1), '0, '0);
      // R7: fully dirty set evicted
      for (int t = 0; t < 4; t++) access(1, mk(t, 1, t), 32'hC0DE_0000 + t, 4'b1111);
      for (int t = 4; t < 8; t++) access(0, mk(t, 1, 0), '0, '0);
      for (int t = 0; t < 4; t++) access(0, mk(t, 1, t), '0, '0);
      // R9: store miss merges into refill
      access(1, mk(6, 2, 1), 32'h5566_7788, 4'b1010);
      access(0, mk(6, 2, 1), '0, '0);
      for (int t = 0; t < 5; t++) access(0, mk(t, 2, 0), '0, '0);
      access(0, mk(6, 2, 1), '0, '0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         access($urandom_range(0, 1) == 1, mk($urandom_range(0, 7), $urandom_range(0, NS - 1), $urandom_range(0, 3)),
                $urandom, 4'($urandom_range(0, 15)));
      end

      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule